// File: doc/BRIEF.md
# Four-Way Cache Controller with Selectable Data-Array Gating

This block is the read/write cache controller that sits between a 32-bit processor and its memory. It holds 8 KB in four ways of 16-byte lines, which gives 128 sets. Tags, valid bits and per-set replacement state are kept in flops. Each way has its own data array, and each array has one enable line. That enable is brought out as a port, so the cost in array activity of every access can be observed directly.

A static input `seqMode` chooses how a read hit reaches the arrays. With `seqMode` low, the block is tuned for a fast clock: all four arrays are read in the same cycle as the tag compare, and the data is ready one cycle after the request. With `seqMode` high, the block is tuned for a slow clock: the tags are compared first, and then only the matching way's array is enabled. This costs one extra cycle but fires a single array.

Writes go through to memory and do not allocate a line on a miss. A read miss fetches the whole line in four word beats and places it in the way named by a round-robin pointer kept for each set. The processor holds its request (address, direction, data, byte enables) stable until `cpuReady` pulses for one cycle.

Top module: `cache_lp_top`

## Requirements
- R1: While reset is asserted and in the first idle cycle after it, `cpuReady`, `memReq` and all four bits of `wayEn` are low. Every line is invalid after reset, so the first read of any address misses.
- R2: The address is decoded as follows: tag = bits 31..11, set index = bits 10..4, word within the line = bits 3..2. Four lines that share an index but have different tags are all resident at the same time and all hit.
- R3: With `seqMode`=0, a read raises all four `wayEn` bits in the request cycle. On a hit, `cpuReady` pulses in the next cycle and `cpuRdata` carries the addressed word in that cycle.
- R4: With `seqMode`=1, a read hit drives `wayEn` to zero in the request cycle. In the next cycle, only the hit way's bit is raised. `cpuReady` pulses with the data in the cycle after that.
- R5: While `seqMode`=1, no more than one bit of `wayEn` is ever high.
- R6: On a read miss, starting two cycles after the request, the block issues four memory reads. They use `memWe`=0 and addresses {line address, beat, 2'b00}, with beats ascending from 0. Each beat is held until `memAck`, and its acknowledge cycle raises only the victim way's `wayEn` bit. `cpuReady` pulses in the cycle after the fourth acknowledge, with the requested word.
- R7: Each set has its own victim pointer. The pointer starts at way 0 and advances by one (wrapping 3 to 0) on each line fill of that set.
- R8: Every write raises `memReq` with `memWe`=1 in the cycle after the request. In that access, `memAddr` equals `cpuAddr`, and `memWdata` and `memBe` equal the processor's data and byte enables (bit i of the enables covers data bits 8i+7..8i). `cpuReady` pulses in the `memAck` cycle.
- R9: On a write hit, in the acknowledge cycle only the hit way's `wayEn` bit is raised, and only the enabled bytes of the cached word change. A write miss raises no `wayEn` bit and installs no line, so a later read of that address misses and returns the written data from memory.
- R10: `cpuReady` is high for one cycle per request. Once `memReq` is raised, it stays high with `memAddr` stable until `memAck`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| seqMode | input | 1 | Static array-access mode: 1 = tag first, then one array |
| cpuReq | input | 1 | Processor request valid, held until cpuReady |
| cpuWe | input | 1 | 1 = write, 0 = read |
| cpuAddr | input | 32 | Byte address |
| cpuWdata | input | 32 | Write data |
| cpuBe | input | 4 | Byte enables for writes |
| cpuReady | output | 1 | One-cycle completion pulse |
| cpuRdata | output | 32 | Read data, valid with cpuReady on reads |
| memReq | output | 1 | Memory request, held until memAck |
| memWe | output | 1 | Memory request is a write |
| memAddr | output | 32 | Memory byte address |
| memWdata | output | 32 | Memory write data |
| memBe | output | 4 | Memory write byte enables |
| memAck | input | 1 | Memory accepts the beat; read data valid with it |
| memRdata | input | 32 | Memory read data |
| wayEn | output | 4 | Per-way data-array enable |

## Verification
A write hit updates the array in the same cycle as its memory acknowledge and its completion pulse. The bench therefore places a read of the same word in the very next cycle. The read must return the byte-merged value, and it must do so through the array-enable pattern predicted for the current mode. Any stale word or mistimed enable appears in that cycle's comparison. The fourth fill beat also coincides with the tag install and the victim-pointer advance. This is provoked by filling one set five times and then re-reading the evicted tags, with the bench model predicting which way's enable must fire on every beat.

// File: rtl/cache_lp_pkg.sv
package cache_lp_pkg;
  parameter int ADDR_W = 32;
  parameter int DATA_W = 32;
  parameter int WAYS   = 4;
  parameter int SETS   = 128;
  parameter int WORDS  = 4;

  localparam int BE_W   = DATA_W / 8;
  localparam int IDX_W  = $clog2(SETS);
  localparam int OFF_W  = $clog2(WORDS);
  localparam int WAY_W  = $clog2(WAYS);
  localparam int BYTE_W = $clog2(BE_W);
  localparam int TAG_W  = ADDR_W - IDX_W - OFF_W - BYTE_W;
  localparam int WA_W   = ADDR_W - BYTE_W;

  typedef struct packed {
    logic [WAYS-1:0]  en;        // per-way array enable
    logic             wr;        // enabled array writes
    logic             fillSrc;   // write data comes from memory
    logic [OFF_W-1:0] word;      // word within line
    logic             tagSet;    // install tag into victim way
    logic             capHit;    // register tag compare result
    logic             respFill;  // answer from captured fill word
  } strobe_t;
endpackage

// File: rtl/cache_lp_dpath.sv
module cache_lp_dpath
  import cache_lp_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           stb,
  input  logic [WA_W-1:0]   wordAddr,
  input  logic [DATA_W-1:0] cpuWdata,
  input  logic [BE_W-1:0]   cpuBe,
  input  logic [DATA_W-1:0] memRdata,
  output logic              hitReg,
  output logic [WAY_W-1:0]  hitWayReg,
  output logic [WAY_W-1:0]  victim,
  output logic [DATA_W-1:0] rdData
);
  logic [TAG_W-1:0] tagOf;
  logic [IDX_W-1:0] idx;
  logic [OFF_W-1:0] wordOff;
  assign tagOf   = wordAddr[WA_W-1 -: TAG_W];
  assign idx     = wordAddr[OFF_W +: IDX_W];
  assign wordOff = wordAddr[OFF_W-1:0];

  logic [TAG_W-1:0] tagArr [WAYS][SETS];
  logic [SETS-1:0]  validArr [WAYS];
  logic [WAY_W-1:0] rrArr [SETS];

  logic [WAYS-1:0]  hitVec;
  logic             hitAny;
  logic [WAY_W-1:0] hitWay;

  for (genvar w = 0; w < WAYS; w++) begin : g_cmp
    assign hitVec[w] = validArr[w][idx] && (tagArr[w][idx] == tagOf);
  end

  always_comb begin
    hitAny = 1'b0;
    hitWay = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (hitVec[w]) begin
        hitAny = 1'b1;
        hitWay = WAY_W'(w);
      end
    end
  end

  assign victim = rrArr[idx];

  always_ff @(posedge clk) begin
    if (stb.tagSet) tagArr[victim][idx] <= tagOf;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      validArr  <= '{default: '0};
      rrArr     <= '{default: '0};
      hitReg    <= 1'b0;
      hitWayReg <= '0;
    end else begin
      if (stb.tagSet) begin
        validArr[victim][idx] <= 1'b1;
        rrArr[idx]            <= victim + 1'b1;
      end
      if (stb.capHit) begin
        hitReg    <= hitAny;
        hitWayReg <= hitWay;
      end
    end
  end

  logic [DATA_W-1:0] wrData;
  logic [BE_W-1:0]   wrBe;
  logic [IDX_W+OFF_W-1:0] arrAddr;
  assign wrData  = stb.fillSrc ? memRdata : cpuWdata;
  assign wrBe    = stb.fillSrc ? {BE_W{1'b1}} : cpuBe;
  assign arrAddr = {idx, stb.word};

  logic [DATA_W-1:0] doutArr [WAYS];

  for (genvar w = 0; w < WAYS; w++) begin : g_way
    logic [DATA_W-1:0] mem [SETS*WORDS];
    always_ff @(posedge clk) begin
      if (stb.en[w]) begin
        if (stb.wr) begin
          for (int b = 0; b < BE_W; b++)
            if (wrBe[b]) mem[arrAddr][8*b +: 8] <= wrData[8*b +: 8];
        end else begin
          doutArr[w] <= mem[arrAddr];
        end
      end
    end
  end

  logic [DATA_W-1:0] critWord;
  always_ff @(posedge clk) begin
    if (stb.fillSrc && stb.wr && stb.word == wordOff) critWord <= memRdata;
  end

  assign rdData = stb.respFill ? critWord : doutArr[hitWayReg];

  // R9: an array write never touches more than the one selected way
  assert_write_one_way_R9: assert property (@(posedge clk) disable iff (!rstN)
    stb.wr |-> $onehot(stb.en));
endmodule

// File: rtl/cache_lp_ctrl.sv
module cache_lp_ctrl
  import cache_lp_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              seqMode,
  input  logic              cpuReq,
  input  logic              cpuWe,
  input  logic [ADDR_W-1:0] cpuAddr,
  input  logic              hitReg,
  input  logic [WAY_W-1:0]  hitWayReg,
  input  logic [WAY_W-1:0]  victim,
  input  logic              memAck,
  output strobe_t           stb,
  output logic              cpuReady,
  output logic              memReq,
  output logic              memWe,
  output logic [ADDR_W-1:0] memAddr
);
  typedef enum logic [2:0] {S_IDLE, S_CHECK, S_SEQRD, S_FILL, S_FDONE, S_WRITE} state_t;
  state_t state, nextState;
  logic [OFF_W-1:0] beat, nextBeat;
  logic [OFF_W-1:0] reqWord;
  assign reqWord = cpuAddr[BYTE_W +: OFF_W];

  localparam logic [WAYS-1:0] ONE_WAY = {{(WAYS-1){1'b0}}, 1'b1};

  always_comb begin
    stb       = '0;
    stb.word  = reqWord;
    nextState = state;
    nextBeat  = beat;
    cpuReady  = 1'b0;
    memReq    = 1'b0;
    memWe     = 1'b0;
    memAddr   = {cpuAddr[ADDR_W-1:BYTE_W+OFF_W], beat, {BYTE_W{1'b0}}};
    unique case (state)
      S_IDLE: begin
        nextBeat = '0;
        if (cpuReq) begin
          stb.capHit = 1'b1;
          if (!cpuWe && !seqMode) stb.en = '1;
          nextState = cpuWe ? S_WRITE : S_CHECK;
        end
      end
      S_CHECK: begin
        if (hitReg) begin
          if (seqMode) begin
            stb.en    = ONE_WAY << hitWayReg;
            nextState = S_SEQRD;
          end else begin
            cpuReady  = 1'b1;
            nextState = S_IDLE;
          end
        end else begin
          nextState = S_FILL;
        end
      end
      S_SEQRD: begin
        cpuReady  = 1'b1;
        nextState = S_IDLE;
      end
      S_FILL: begin
        memReq = 1'b1;
        if (memAck) begin
          stb.en      = ONE_WAY << victim;
          stb.wr      = 1'b1;
          stb.fillSrc = 1'b1;
          stb.word    = beat;
          nextBeat    = beat + 1'b1;
          if (beat == OFF_W'(WORDS-1)) begin
            stb.tagSet = 1'b1;
            nextState  = S_FDONE;
          end
        end
      end
      S_FDONE: begin
        cpuReady     = 1'b1;
        stb.respFill = 1'b1;
        nextState    = S_IDLE;
      end
      S_WRITE: begin
        memReq  = 1'b1;
        memWe   = 1'b1;
        memAddr = cpuAddr;
        if (memAck) begin
          cpuReady  = 1'b1;
          nextState = S_IDLE;
          if (hitReg) begin
            stb.en = ONE_WAY << hitWayReg;
            stb.wr = 1'b1;
          end
        end
      end
      default: nextState = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= S_IDLE;
      beat  <= '0;
    end else begin
      state <= nextState;
      beat  <= nextBeat;
    end
  end

  // R5: slow-clock mode fires one array at most
  assert_seq_single_en_R5: assert property (@(posedge clk) disable iff (!rstN)
    seqMode |-> $onehot0(stb.en));
  // R10: completion is a single-cycle pulse
  assert_ready_pulse_R10: assert property (@(posedge clk) disable iff (!rstN)
    cpuReady |=> !cpuReady);
  // R10: a memory request waits for its acknowledge
  assert_memreq_hold_R10: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && !memAck) |=> memReq);
  // R6: beat address does not move before acknowledge
  assert_memaddr_stable_R6: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && !memAck) |=> $stable(memAddr));
endmodule

// File: rtl/cache_lp_top.sv
module cache_lp_top
  import cache_lp_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              seqMode,
  input  logic              cpuReq,
  input  logic              cpuWe,
  input  logic [ADDR_W-1:0] cpuAddr,
  input  logic [DATA_W-1:0] cpuWdata,
  input  logic [BE_W-1:0]   cpuBe,
  output logic              cpuReady,
  output logic [DATA_W-1:0] cpuRdata,
  output logic              memReq,
  output logic              memWe,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memWdata,
  output logic [BE_W-1:0]   memBe,
  input  logic              memAck,
  input  logic [DATA_W-1:0] memRdata,
  output logic [WAYS-1:0]   wayEn
);
  strobe_t          stb;
  logic             hitReg;
  logic [WAY_W-1:0] hitWayReg;
  logic [WAY_W-1:0] victim;

  cache_lp_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .seqMode(seqMode), .cpuReq(cpuReq), .cpuWe(cpuWe),
    .cpuAddr(cpuAddr), .hitReg(hitReg), .hitWayReg(hitWayReg), .victim(victim),
    .memAck(memAck), .stb(stb), .cpuReady(cpuReady), .memReq(memReq),
    .memWe(memWe), .memAddr(memAddr)
  );

  cache_lp_dpath u_dpath (
    .clk(clk), .rstN(rstN), .stb(stb), .wordAddr(cpuAddr[ADDR_W-1:BYTE_W]),
    .cpuWdata(cpuWdata), .cpuBe(cpuBe), .memRdata(memRdata), .hitReg(hitReg),
    .hitWayReg(hitWayReg), .victim(victim), .rdData(cpuRdata)
  );

  assign memWdata = cpuWdata;
  assign memBe    = cpuBe;
  assign wayEn    = stb.en;
endmodule

// File: tb/sim_cache_lp_top.sv
module sim_cache_lp_top;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic seqMode = 1'b0;
  logic cpuReq = 1'b0, cpuWe = 1'b0;
  logic [31:0] cpuAddr = '0, cpuWdata = '0;
  logic [3:0]  cpuBe = '0;
  logic cpuReady, memReq, memWe;
  logic [31:0] cpuRdata, memAddr, memWdata;
  logic [3:0]  memBe, wayEn;
  logic memAck = 1'b0;
  logic [31:0] memRdata = '0;

  always #5 clk = ~clk;

  cache_lp_top u0 (
    .clk(clk), .rstN(rstN), .seqMode(seqMode), .cpuReq(cpuReq), .cpuWe(cpuWe),
    .cpuAddr(cpuAddr), .cpuWdata(cpuWdata), .cpuBe(cpuBe), .cpuReady(cpuReady),
    .cpuRdata(cpuRdata), .memReq(memReq), .memWe(memWe), .memAddr(memAddr),
    .memWdata(memWdata), .memBe(memBe), .memAck(memAck), .memRdata(memRdata),
    .wayEn(wayEn)
  );

  int checks = 0, errors = 0;
  bit finished = 0;
  logic [31:0] memStore [logic [31:0]];
  int  mTag   [4][128];
  bit  mValid [4][128];
  int  mRr    [128];

  function automatic logic [31:0] rdMem(input logic [31:0] a);
    logic [31:0] wa = {a[31:2], 2'b00};
    if (memStore.exists(wa)) return memStore[wa];
    return (wa * 32'h9E3779B1) ^ 32'h5A5A0F0F;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // memory responds in the same cycle it sees a request
  always @(negedge clk) begin
    memAck   = memReq;
    memRdata = rdMem(memAddr);
  end

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0; cpuReq = 1'b0;
    for (int s = 0; s < 128; s++) begin
      mRr[s] = 0;
      for (int w = 0; w < 4; w++) begin mValid[w][s] = 0; mTag[w][s] = 0; end
    end
    repeat (3) @(negedge clk);
    #3;
    chk(cpuReady == 0 && memReq == 0 && wayEn == 0, "R1 during reset", {cpuReady, memReq, wayEn}, 0);
    @(negedge clk);
    rstN = 1'b1;
    #3;
    chk(cpuReady == 0 && memReq == 0 && wayEn == 0, "R1 after reset", {cpuReady, memReq, wayEn}, 0);
  endtask

  task automatic access(input bit we, input logic [31:0] a, input logic [31:0] wd, input logic [3:0] be);
    int idx = int'(a[10:4]);
    int tg  = int'(a[31:11]);
    bit hit = 0;
    int hw  = 0;
    int vic = mRr[idx];
    int n;
    logic [3:0] expEn [8];
    bit expRdy [8];
    string tagName;
    logic [31:0] expData;
    for (int w = 0; w < 4; w++) if (mValid[w][idx] && mTag[w][idx] == tg) begin hit = 1; hw = w; end
    for (int k = 0; k < 8; k++) begin expEn[k] = 4'h0; expRdy[k] = 0; end
    if (we) begin
      n = 2; expRdy[1] = 1;
      if (hit) expEn[1] = 4'b0001 << hw;
      tagName = hit ? "R9 write hit" : "R9 write miss";
    end else if (hit && !seqMode) begin
      n = 2; expEn[0] = 4'hF; expRdy[1] = 1; tagName = "R3 fast hit";
    end else if (hit) begin
      n = 3; expEn[1] = 4'b0001 << hw; expRdy[2] = 1; tagName = "R4 slow hit";
    end else begin
      n = 7; expEn[0] = seqMode ? 4'h0 : 4'hF; expRdy[6] = 1;
      for (int k = 2; k < 6; k++) expEn[k] = 4'b0001 << vic;
      tagName = "R6 R7 miss fill";
    end
    expData = rdMem(a);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      if (k == 0) begin cpuReq = 1; cpuWe = we; cpuAddr = a; cpuWdata = wd; cpuBe = be; end
      #3;
      chk(wayEn == expEn[k], seqMode ? {tagName, " R5 enables"} : {tagName, " enables"}, {28'd0, wayEn}, {28'd0, expEn[k]});
      chk(cpuReady == expRdy[k], {tagName, " R10 ready timing"}, {31'd0, cpuReady}, {31'd0, expRdy[k]});
      if (expRdy[k] && !we) chk(cpuRdata == expData, {tagName, " R2 data"}, cpuRdata, expData);
      if (!we && !hit && k >= 2 && k < 6)
        chk(memReq && !memWe && memAddr == {a[31:4], 2'(k-2), 2'b00}, "R6 beat address", memAddr, {a[31:4], 2'(k-2), 2'b00});
      if (we && k == 1) begin
        chk(memReq && memWe && memAddr == a, "R8 write address", memAddr, a);
        chk(memWdata == wd && memBe == be, "R8 write data", memWdata, wd);
      end
    end
    if (we) begin
      logic [31:0] old = rdMem(a);
      for (int b = 0; b < 4; b++) if (be[b]) old[8*b +: 8] = wd[8*b +: 8];
      memStore[{a[31:2], 2'b00}] = old;
    end else if (!hit) begin
      mTag[vic][idx] = tg; mValid[vic][idx] = 1; mRr[idx] = (vic + 1) % 4;
    end
  endtask

  function automatic logic [31:0] mk(input int tg, input int idx, input int wd);
    return (32'(tg) << 11) | (32'(idx) << 4) | (32'(wd) << 2);
  endfunction

  task automatic phase(input bit mode);
    seqMode = mode;
    doReset();
    access(0, mk(2, 4, 2), 0, 0);          // R1 first read misses
    access(0, mk(2, 4, 2), 0, 0);          // R3/R4 hit
    access(0, mk(2, 4, 3), 0, 0);          // other word same line
    for (int t = 3; t <= 5; t++) access(0, mk(t, 4, 0), 0, 0);  // R2 four tags, one set
    for (int t = 2; t <= 5; t++) access(0, mk(t, 4, 1), 0, 0);  // R2 all resident
    access(0, mk(6, 4, 0), 0, 0);          // R7 wraps to way 0
    access(0, mk(2, 4, 0), 0, 0);          // evicted, refills way 1
    access(0, mk(4, 4, 0), 0, 0);          // still hits
    access(0, mk(7, 9, 1), 0, 0);          // R7 other set starts at way 0
    access(1, mk(4, 4, 1), 32'hAABBCCDD, 4'b0101);  // R9 write hit, partial
    access(0, mk(4, 4, 1), 0, 0);          // back-to-back read sees merge
    access(1, mk(30, 4, 2), 32'h13572468, 4'hF);    // R9 write miss
    access(0, mk(30, 4, 2), 0, 0);         // no allocate: misses
    @(negedge clk);
    cpuReq = 0;
  endtask

  initial begin
    phase(0);
    phase(1);
    repeat (2) @(negedge clk);
    if (!finished) begin
      finished = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; errors++;
      $display("FAIL watchdog actual=%h expected=%h", 32'd1, 32'd0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule